// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Cause and Mask

This block holds two independent 32-bit down-counters behind a plain 32-bit register port. Each counter has a reload register and a value register, and software can write both. One shared control word starts and stops both counters. The same word picks, per counter, between running once and reloading itself. Typical uses are a free-running timebase that wraps through the full 32-bit range and a programmable tick that fires once or at a fixed period.

Each counter raises a terminal event at the clock edge where it is enabled and sits at zero. That event latches a bit in a cause register. A mask register decides which latched causes drive the per-timer interrupt outputs. Software clears cause bits by writing a pattern: a 0 clears the bit, a 1 keeps it. Register reads are combinational from the byte address. A write takes effect at the next rising clock.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The control word is at offset 0x00. Bit 0 enables timer 0, bit 1 selects auto-reload for timer 0, bit 2 enables timer 1, and bit 3 selects auto-reload for timer 1. Bits 31:4 read as zero.
- R3: Timer 0 has its reload register at 0x10 and its value register at 0x14. Timer 1 has its reload register at 0x18 and its value register at 0x1C. All four are fully readable and writable.
- R4: An enabled counter above zero decrements by one on each clock, and reading its value register returns the live count. A disabled counter holds its value.
- R5: An enabled counter at zero with auto-reload set loads its reload value on the next clock. The period is therefore reload+1 clocks.
- R6: An enabled counter at zero with auto-reload clear stays at zero, and its enable bit in the control word clears on that clock. A control write in the same cycle takes priority over this clear.
- R7: The cause register is at 0x110. Bit 1 belongs to timer 0 and bit 2 to timer 1. A cause bit becomes set at the clock edge where its counter is enabled and at zero. All other bits read as zero.
- R8: A write to the cause register clears each cause bit written as 0 and leaves each bit written as 1 unchanged. If a terminal event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: The mask register is at 0x114, using the same bit positions as the cause register. `irq_o[t]` is high exactly when timer t's cause bit and mask bit are both set. Clearing a mask bit does not stop the counter.
- R10: A write to a value register loads the counter on the next clock. It overrides any decrement or reload in that cycle and suppresses the terminal event for that cycle.
- R11: Reads from unmapped offsets return zero. Writes to unmapped offsets change no register.
- R12: When the value and reload registers both hold 0xFFFFFFFF and enable and reload are set, the counter runs through the whole 32-bit range and wraps from 0 to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counters tick on each rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 2 | Per-timer interrupt, cause AND mask |

## Verification
The bench aims at the terminal-count edge, which is where most designs go wrong.

- **Off-by-one period:** a counter that reloads one clock early or late gives a period of reload or reload+2 instead of reload+1. Randomly chosen start values, reload values and wait lengths expose this in the value readback.
- **Clear beating the set:** a cause clear written on the exact edge of a terminal event loses the interrupt if the clear is allowed to win.
- **Value write losing to the counter:** a value write that lands on a zero count is dropped, or raises a spurious cause, if the counter's own update wins.
- **One-shot enable left set:** a one-shot counter that does not clear its enable bit shows up in the control readback.
- **Wrap and decode errors:** the full-range wrap and the unmapped offsets catch width and decode mistakes.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned OFF_CTRL  = 32'h000;
  localparam int unsigned OFF_CAUSE = 32'h110;
  localparam int unsigned OFF_MASK  = 32'h114;
  // cause and mask bit for timer t is t + CAUSE_LSB
  localparam int unsigned CAUSE_LSB = 1;

  function automatic int unsigned rld_off(input int unsigned t);
    return 32'h010 + 8 * t;
  endfunction

  function automatic int unsigned val_off(input int unsigned t);
    return 32'h014 + 8 * t;
  endfunction
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic             val_we_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             tc_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  // software value write masks the terminal event of that cycle
  assign tc_o    = run_i && at_zero && !val_we_i;
  assign stop_o  = tc_o && !auto_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (val_we_i) begin
      cnt_q <= wdata_i;
    end else if (run_i) begin
      if (!at_zero)    cnt_q <= cnt_q - CNT_W'(1);
      else if (auto_i) cnt_q <= rld_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_we_i) rld_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl #(
  parameter int unsigned NUM_TMR = 2,
  localparam int unsigned CTRL_W = 2 * NUM_TMR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CTRL_W-1:0]  wdata_i,
  input  logic [NUM_TMR-1:0] stop_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [NUM_TMR-1:0] run_o,
  output logic [NUM_TMR-1:0] auto_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    for (int t = 0; t < NUM_TMR; t++)
      if (stop_i[t]) ctrl_d[2*t] = 1'b0;
    // software write has priority over one-shot self clear
    if (we_i) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_fld
    assign run_o[t]  = ctrl_q[2*t];
    assign auto_o[t] = ctrl_q[2*t+1];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int unsigned NUM_TMR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cause_we_i,
  input  logic               mask_we_i,
  input  logic [NUM_TMR-1:0] wdata_i,
  input  logic [NUM_TMR-1:0] tc_i,
  output logic [NUM_TMR-1:0] cause_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic [NUM_TMR-1:0] cause_q, mask_q, cause_keep;

  // written 0 clears, written 1 keeps; a set in the same cycle wins
  assign cause_keep = cause_we_i ? (cause_q & wdata_i) : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_keep | tc_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = cause_q & mask_q;
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dtmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CTRL_W = 2 * NUM_TMR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic                           sel_ctrl, sel_cause, sel_mask;
  logic [NUM_TMR-1:0]             sel_val, sel_rld;
  logic [NUM_TMR-1:0]             val_we_w, rld_we_w;
  logic [NUM_TMR-1:0]             run_w, auto_w, tc_w, stop_w;
  logic [NUM_TMR-1:0]             cause_w, mask_w;
  logic [CTRL_W-1:0]              ctrl_w;
  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_w, rld_w;

  assign sel_ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_cause = (addr_i == ADDR_W'(OFF_CAUSE));
  assign sel_mask  = (addr_i == ADDR_W'(OFF_MASK));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign sel_val[t]  = (addr_i == ADDR_W'(val_off(t)));
    assign sel_rld[t]  = (addr_i == ADDR_W'(rld_off(t)));
    assign val_we_w[t] = wr_en_i && sel_val[t];
    assign rld_we_w[t] = wr_en_i && sel_rld[t];

    dtmr_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_w[t]),
      .auto_i   (auto_w[t]),
      .val_we_i (val_we_w[t]),
      .rld_we_i (rld_we_w[t]),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_w[t]),
      .rld_o    (rld_w[t]),
      .tc_o     (tc_w[t]),
      .stop_o   (stop_w[t])
    );
  end

  dtmr_ctrl #(.NUM_TMR(NUM_TMR)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && sel_ctrl),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .stop_i  (stop_w),
    .ctrl_o  (ctrl_w),
    .run_o   (run_w),
    .auto_o  (auto_w)
  );

  dtmr_irq #(.NUM_TMR(NUM_TMR)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cause_we_i (wr_en_i && sel_cause),
    .mask_we_i  (wr_en_i && sel_mask),
    .wdata_i    (wdata_i[CAUSE_LSB +: NUM_TMR]),
    .tc_i       (tc_w),
    .cause_o    (cause_w),
    .mask_o     (mask_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)  rdata_o[CTRL_W-1:0] = ctrl_w;
    if (sel_cause) rdata_o[CAUSE_LSB +: NUM_TMR] = cause_w;
    if (sel_mask)  rdata_o[CAUSE_LSB +: NUM_TMR] = mask_w;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (sel_rld[t]) rdata_o = rld_w[t];
      if (sel_val[t]) rdata_o = cnt_w[t];
    end
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned CNT_W   = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_TMR-1:0]            run_i,
  input logic [NUM_TMR-1:0]            auto_i,
  input logic [NUM_TMR-1:0]            val_we_i,
  input logic                          ctrl_we_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0] rld_i,
  input logic [NUM_TMR-1:0]            cause_i,
  input logic [NUM_TMR-1:0]            mask_i,
  input logic [NUM_TMR-1:0]            irq_i
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[t] && !val_we_i[t] && cnt_i[t] != '0 |=> cnt_i[t] == $past(cnt_i[t]) - CNT_W'(1));

    assert_hold_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[t] && !val_we_i[t] |=> $stable(cnt_i[t]));

    assert_auto_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[t] && auto_i[t] && cnt_i[t] == '0 && !val_we_i[t] |=> cnt_i[t] == $past(rld_i[t]));

    assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[t] && !auto_i[t] && cnt_i[t] == '0 && !val_we_i[t] && !ctrl_we_i
      |=> !run_i[t] && cnt_i[t] == '0);

    assert_tc_sets_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[t] && cnt_i[t] == '0 && !val_we_i[t] |=> cause_i[t]);

    assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mask_i[t] |-> !irq_i[t]);

    assert_value_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_we_i[t] |=> cnt_i[t] == $past(wdata_i));
  end
endmodule

bind dual_timer_irq dtmr_checker #(.NUM_TMR(NUM_TMR), .CNT_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_w),
  .auto_i    (auto_w),
  .val_we_i  (val_we_w),
  .ctrl_we_i (wr_en_i && sel_ctrl),
  .wdata_i   (wdata_i),
  .cnt_i     (cnt_w),
  .rld_i     (rld_w),
  .cause_i   (cause_w),
  .mask_i    (mask_w),
  .irq_i     (irq_o)
);

// File: tb/dual_timer_irq_tb_top.sv
module dual_timer_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_RLD0  = 12'h010;
  localparam logic [11:0] A_VAL0  = 12'h014;
  localparam logic [11:0] A_RLD1  = 12'h018;
  localparam logic [11:0] A_VAL1  = 12'h01C;
  localparam logic [11:0] A_CAUSE = 12'h110;
  localparam logic [11:0] A_MASK  = 12'h114;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_irq dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // called at a negedge; the following posedge captures the write
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // count after n clocks from start v (R4, R5, R6)
  function automatic logic [31:0] exp_cnt(input int v, input int r, input int n, input bit auto_rl);
    if (n <= v) return 32'(v - n);
    if (!auto_rl) return 32'd0;
    return 32'(r - ((n - v - 1) % (r + 1)));
  endfunction

  function automatic logic [11:0] val_a(input int t);
    return (t == 0) ? A_VAL0 : A_VAL1;
  endfunction

  function automatic logic [11:0] rld_a(input int t);
    return (t == 0) ? A_RLD0 : A_RLD1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 ctrl", A_CTRL, 32'h0);
    chk_rd("R1 rld0", A_RLD0, 32'h0);
    chk_rd("R1 val0", A_VAL0, 32'h0);
    chk_rd("R1 rld1", A_RLD1, 32'h0);
    chk_rd("R1 val1", A_VAL1, 32'h0);
    chk_rd("R1 cause", A_CAUSE, 32'h0);
    chk_rd("R1 mask", A_MASK, 32'h0);
    chk("R1 irq", {30'd0, irq}, 32'h0);

    // R2 control field layout
    wr(A_CTRL, 32'hFFFF_FFF0);
    chk_rd("R2 upper bits", A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0000_000A);
    chk_rd("R2 reload bits only", A_CTRL, 32'hA);

    // R3 register map read/write
    wr(A_RLD0, 32'h1234_5678);
    wr(A_RLD1, 32'h9ABC_DEF0);
    wr(A_VAL1, 32'h0F0F_0F0F);
    wr(A_VAL0, 32'h0000_0077);
    chk_rd("R3 rld0", A_RLD0, 32'h1234_5678);
    chk_rd("R3 rld1", A_RLD1, 32'h9ABC_DEF0);
    chk_rd("R3 val1", A_VAL1, 32'h0F0F_0F0F);

    // R4 disabled counters hold
    repeat (5) @(negedge clk);
    chk_rd("R4 hold val0", A_VAL0, 32'h77);
    chk_rd("R4 hold val1", A_VAL1, 32'h0F0F_0F0F);

    // R4 R5 R6 R7 random runs
    for (int i = 0; i < 24; i++) begin
      int t, v, r, n;
      bit a;
      logic [31:0] d, ectrl;
      t = int'($urandom % 2);
      a = 1'($urandom % 2);
      v = int'($urandom % 40);
      r = int'($urandom % 30);
      n = int'($urandom % 100);
      wr(A_CTRL, 32'h0);
      wr(A_CAUSE, 32'h0);
      wr(rld_a(t), 32'(r));
      wr(val_a(t), 32'(v));
      wr(A_CTRL, (a ? 32'h3 : 32'h1) << (2 * t));
      repeat (n) @(negedge clk);
      rd(val_a(t), d);
      chk(a ? "R5 periodic count" : "R6 one-shot count", d, exp_cnt(v, r, n, a));
      ectrl = a ? 32'h3 : ((n <= v) ? 32'h1 : 32'h0);
      rd(A_CTRL, d);
      chk(a ? "R4 ctrl kept" : "R6 enable self clear", d, ectrl << (2 * t));
      rd(A_CAUSE, d);
      chk("R7 cause", d, (n >= v + 1) ? (32'h2 << t) : 32'h0);
    end

    // R8 partial clear pattern
    wr(A_CTRL, 32'h0);
    wr(A_CAUSE, 32'h0);
    wr(A_VAL0, 32'h0);
    wr(A_VAL1, 32'h0);
    wr(A_CTRL, 32'h5);
    @(negedge clk);
    chk_rd("R7 both causes", A_CAUSE, 32'h6);
    chk_rd("R6 both stopped", A_CTRL, 32'h0);
    wr(A_CAUSE, 32'hFFFF_FFFB);
    chk_rd("R8 clear bit2 only", A_CAUSE, 32'h2);
    wr(A_CAUSE, 32'h0);
    chk_rd("R8 clear all", A_CAUSE, 32'h0);

    // R8 set beats clear on the same edge
    wr(A_VAL0, 32'd3);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    wr(A_CAUSE, 32'h0);
    chk_rd("R8 set wins", A_CAUSE, 32'h2);

    // R9 mask gating
    wr(A_MASK, 32'h0);
    chk("R9 masked irq low", {30'd0, irq}, 32'h0);
    wr(A_MASK, 32'hFFFF_FFFF);
    chk_rd("R9 mask readback", A_MASK, 32'h6);
    chk("R9 irq timer0", {30'd0, irq}, 32'h1);
    wr(A_MASK, 32'h0);
    wr(A_CAUSE, 32'h0);
    wr(A_RLD1, 32'd9);
    wr(A_VAL1, 32'd9);
    wr(A_CTRL, 32'hC);
    repeat (4) @(negedge clk);
    chk_rd("R9 counter runs while masked", A_VAL1, 32'd5);
    repeat (6) @(negedge clk);
    chk_rd("R9 wrapped while masked", A_VAL1, exp_cnt(9, 9, 10, 1'b1));
    chk_rd("R9 cause latched", A_CAUSE, 32'h4);
    chk("R9 irq suppressed", {30'd0, irq}, 32'h0);
    wr(A_MASK, 32'h4);
    chk("R9 irq timer1", {30'd0, irq}, 32'h2);

    // R10 value write on the zero cycle
    wr(A_MASK, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_CAUSE, 32'h0);
    wr(A_RLD0, 32'd5);
    wr(A_VAL0, 32'd2);
    wr(A_CTRL, 32'h3);
    repeat (2) @(negedge clk);
    wr(A_VAL0, 32'd9);
    chk_rd("R10 write overrides reload", A_VAL0, 32'd9);
    chk_rd("R10 no terminal event", A_CAUSE, 32'h0);

    // R11 unmapped offsets
    wr(12'h020, 32'hDEAD_BEEF);
    chk_rd("R11 read 0x20", 12'h020, 32'h0);
    chk_rd("R11 read 0x04", 12'h004, 32'h0);
    chk_rd("R11 read 0x118", 12'h118, 32'h0);
    chk_rd("R11 rld0 untouched", A_RLD0, 32'd5);
    chk_rd("R11 ctrl untouched", A_CTRL, 32'h3);

    // R12 full-range free run
    wr(A_CTRL, 32'h0);
    wr(A_VAL0, 32'hFFFF_FFFF);
    wr(A_RLD0, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h3);
    repeat (5) @(negedge clk);
    chk_rd("R12 free run", A_VAL0, 32'hFFFF_FFFA);
    wr(A_CTRL, 32'h0);
    wr(A_VAL0, 32'd2);
    wr(A_CTRL, 32'h3);
    repeat (3) @(negedge clk);
    chk_rd("R12 wrap to max", A_VAL0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_rd("R12 after wrap", A_VAL0, 32'hFFFF_FFFE);

    summary();
    $finish;
  end
endmodule